// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This unit takes trap requests for a three-level (machine, supervisor, user) core and performs the architectural side of taking the trap. Each request carries a valid strobe, an interrupt/exception flag, a cause code, the address of the trapping instruction and a trap value. From the current privilege level and four delegation masks, the unit picks the level that handles the trap. There is one interrupt mask and one exception mask at machine level, and one of each at supervisor level. The unit then writes that level's cause, return-address and trap-value registers, stacks the interrupt-enable bits in the status word, switches privilege, and issues a registered redirect to the handler.

The handler address is taken from the selected level's trap-vector input. In vectored mode an interrupt lands at an offset scaled by its cause code. Every other case lands on the base. The status word and the privilege level can also be written by the surrounding core, which uses this for CSR writes and for the return path. A trap that arrives in the same cycle as such a write takes precedence over it. Reset puts the unit in machine mode with a cleared status and redirects to a fixed reset address.

Top module: `trap_entry_ctrl`

## Requirements
- R1: The handler level is machine (priv code 3) by default. It becomes supervisor (code 1) when the current level is not machine and bit `trap_code` of the machine mask is set. The machine mask is `m_ideleg` for interrupts and `m_edeleg` for exceptions.
- R2: The handler level becomes user (code 0) when the current level is user and bit `trap_code` of the supervisor mask is set. The supervisor mask is `s_ideleg` for interrupts and `s_edeleg` for exceptions. The privilege output takes the handler level on the edge after the trap.
- R3: The selected level's cause register receives the cause code in its low bits and the interrupt flag in bit XLEN-1. All other bits are zero.
- R4: The selected level's return-address register receives `trap_pc` and its trap-value register receives `trap_tval`. The registers of the other two levels are left unchanged.
- R5: When the handler is supervisor, status bit 8 takes the old privilege (1 = supervisor, 0 = user), bit 5 takes the old bit 1, and bit 1 is cleared.
- R6: When the handler is user, status bit 4 takes the old bit 0 and bit 0 is cleared.
- R7: When the handler is machine, status bits 12:11 take the old privilege code, bit 7 takes the old bit 3, and bit 3 is cleared.
- R8: The handler base is the selected level's trap-vector input with bits 1:0 forced to zero. If those bits equal 1 and the trap is an interrupt, the target is base + 4*cause. For any other mode value, or for an exception, the target is the base.
- R9: `redir_pc` and `redir_valid` are registered. `redir_valid` is high for exactly the cycle after each cycle with `trap_valid`.
- R10: While `rst_n` is low, the privilege level is 3, the status word, all cause registers and `redir_valid` are 0, and `redir_pc` equals RESET_PC.
- R11: When `st_we` is high and no trap is requested, the status word takes `st_wdata` masked to bits {0,1,3,4,5,7,8,11,12,17}. When `trap_valid` is high, `st_we` is ignored.
- R12: When `priv_we` is high and no trap is requested, the privilege level takes `priv_wdata`. With neither a trap nor a write, the privilege level and status word hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | Trap request strobe |
| trap_is_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_code | input | $clog2(XLEN) | Cause code |
| trap_pc | input | XLEN | Address of trapping instruction |
| trap_tval | input | XLEN | Trap value |
| m_ideleg | input | XLEN | Machine interrupt delegation mask |
| m_edeleg | input | XLEN | Machine exception delegation mask |
| s_ideleg | input | XLEN | Supervisor interrupt delegation mask |
| s_edeleg | input | XLEN | Supervisor exception delegation mask |
| m_tvec | input | XLEN | Machine trap vector |
| s_tvec | input | XLEN | Supervisor trap vector |
| u_tvec | input | XLEN | User trap vector |
| st_we | input | 1 | Status write enable |
| st_wdata | input | XLEN | Status write data |
| priv_we | input | 1 | Privilege write enable |
| priv_wdata | input | 2 | Privilege write data |
| priv | output | 2 | Current privilege level |
| status | output | XLEN | Status word |
| m_cause | output | XLEN | Machine cause |
| m_epc | output | XLEN | Machine return address |
| m_tval | output | XLEN | Machine trap value |
| s_cause | output | XLEN | Supervisor cause |
| s_epc | output | XLEN | Supervisor return address |
| s_tval | output | XLEN | Supervisor trap value |
| u_cause | output | XLEN | User cause |
| u_epc | output | XLEN | User return address |
| u_tval | output | XLEN | User trap value |
| redir_valid | output | 1 | One-cycle redirect pulse |
| redir_pc | output | XLEN | Redirect target |

## Verification
A trap and a status or privilege write can fall in the same cycle. In that case the trap's stacking must win and the written value must be dropped. The stimulus raises `st_we` and `priv_we` at random, alongside random traps and delegation masks. It also includes a directed cycle that presents all three at once with a status value that differs from the stacked one. Each clock is judged against a behavioural model that applies the trap and ignores the writes.

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = 'h1000,
  localparam int CW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_valid,
  input  logic            trap_is_irq,
  input  logic [CW-1:0]   trap_code,
  input  logic [XLEN-1:0] trap_pc,
  input  logic [XLEN-1:0] trap_tval,
  input  logic [XLEN-1:0] m_ideleg,
  input  logic [XLEN-1:0] m_edeleg,
  input  logic [XLEN-1:0] s_ideleg,
  input  logic [XLEN-1:0] s_edeleg,
  input  logic [XLEN-1:0] m_tvec,
  input  logic [XLEN-1:0] s_tvec,
  input  logic [XLEN-1:0] u_tvec,
  input  logic            st_we,
  input  logic [XLEN-1:0] st_wdata,
  input  logic            priv_we,
  input  logic [1:0]      priv_wdata,
  output logic [1:0]      priv,
  output logic [XLEN-1:0] status,
  output logic [XLEN-1:0] m_cause,
  output logic [XLEN-1:0] m_epc,
  output logic [XLEN-1:0] m_tval,
  output logic [XLEN-1:0] s_cause,
  output logic [XLEN-1:0] s_epc,
  output logic [XLEN-1:0] s_tval,
  output logic [XLEN-1:0] u_cause,
  output logic [XLEN-1:0] u_epc,
  output logic [XLEN-1:0] u_tval,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc
);
  localparam logic [1:0] LV_U = 2'd0, LV_S = 2'd1, LV_M = 2'd3;
  localparam int B_UIE = 0, B_SIE = 1, B_MIE = 3, B_UPIE = 4, B_SPIE = 5;
  localparam int B_MPIE = 7, B_SPP = 8, B_MPP = 11, B_MPRV = 17;
  localparam logic [XLEN-1:0] ST_MASK = XLEN'((1 << B_UIE) | (1 << B_SIE) |
    (1 << B_MIE) | (1 << B_UPIE) | (1 << B_SPIE) | (1 << B_MPIE) |
    (1 << B_SPP) | (3 << B_MPP) | (1 << B_MPRV));

  logic [XLEN-1:0] mdel, sdel, tvec, base, target, cause_val, st_next;
  logic [1:0]      lvl;

  assign mdel = trap_is_irq ? m_ideleg : m_edeleg;
  assign sdel = trap_is_irq ? s_ideleg : s_edeleg;

  always_comb begin
    lvl = LV_M;
    if (priv != LV_M && mdel[trap_code]) lvl = LV_S;
    if (priv == LV_U && sdel[trap_code]) lvl = LV_U;
  end

  always_comb begin
    case (lvl)
      LV_U:    tvec = u_tvec;
      LV_S:    tvec = s_tvec;
      default: tvec = m_tvec;
    endcase
  end

  assign base      = {tvec[XLEN-1:2], 2'b00};
  assign target    = (trap_is_irq && tvec[1:0] == 2'b01) ?
                     base + (XLEN'(trap_code) << 2) : base;
  assign cause_val = {trap_is_irq, {(XLEN-1-CW){1'b0}}, trap_code};

  always_comb begin
    st_next = status;
    case (lvl)
      LV_U: begin
        st_next[B_UPIE] = status[B_UIE];
        st_next[B_UIE]  = 1'b0;
      end
      LV_S: begin
        st_next[B_SPP]  = priv[0];
        st_next[B_SPIE] = status[B_SIE];
        st_next[B_SIE]  = 1'b0;
      end
      default: begin
        st_next[B_MPP +: 2] = priv;
        st_next[B_MPIE]     = status[B_MIE];
        st_next[B_MIE]      = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv        <= LV_M;
      status      <= '0;
      m_cause     <= '0;
      m_epc       <= '0;
      m_tval      <= '0;
      s_cause     <= '0;
      s_epc       <= '0;
      s_tval      <= '0;
      u_cause     <= '0;
      u_epc       <= '0;
      u_tval      <= '0;
      redir_valid <= 1'b0;
      redir_pc    <= RESET_PC;
    end else begin
      redir_valid <= trap_valid;
      if (trap_valid) begin
        priv     <= lvl;
        status   <= st_next;
        redir_pc <= target;
        case (lvl)
          LV_U: begin
            u_cause <= cause_val;
            u_epc   <= trap_pc;
            u_tval  <= trap_tval;
          end
          LV_S: begin
            s_cause <= cause_val;
            s_epc   <= trap_pc;
            s_tval  <= trap_tval;
          end
          default: begin
            m_cause <= cause_val;
            m_epc   <= trap_pc;
            m_tval  <= trap_tval;
          end
        endcase
      end else begin
        if (st_we)   status <= st_wdata & ST_MASK;
        if (priv_we) priv   <= priv_wdata;
      end
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int XLEN = 32,
  localparam int CW = $clog2(XLEN)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_valid,
  input logic            trap_is_irq,
  input logic [CW-1:0]   trap_code,
  input logic [XLEN-1:0] trap_pc,
  input logic [XLEN-1:0] trap_tval,
  input logic            priv_we,
  input logic [1:0]      priv,
  input logic [XLEN-1:0] status,
  input logic [XLEN-1:0] m_cause,
  input logic [XLEN-1:0] m_epc,
  input logic [XLEN-1:0] m_tval,
  input logic            redir_valid
);
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> redir_valid);
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |=> !redir_valid);
  p_mstay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && priv == 2'd3) |=> priv == 2'd3);
  p_mcause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && priv == 2'd3) |=>
      m_cause == {$past(trap_is_irq), {(XLEN-1-CW){1'b0}}, $past(trap_code)});
  p_mepc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && priv == 2'd3) |=>
      (m_epc == $past(trap_pc) && m_tval == $past(trap_tval)));
  p_mstack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && priv == 2'd3) |=>
      (!status[3] && status[7] == $past(status[3]) && status[12:11] == 2'd3));
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_valid && !priv_we) |=> $stable(priv));
endmodule

bind trap_entry_ctrl trap_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_is_irq(trap_is_irq),
  .trap_code(trap_code), .trap_pc(trap_pc), .trap_tval(trap_tval),
  .priv_we(priv_we), .priv(priv), .status(status), .m_cause(m_cause),
  .m_epc(m_epc), .m_tval(m_tval), .redir_valid(redir_valid)
);

// File: tb/tb_trap_entry_ctrl.sv
`timescale 1ns/1ps
module tb_trap_entry_ctrl;
  localparam int XLEN = 32;
  localparam int CW = $clog2(XLEN);
  localparam logic [XLEN-1:0] RPC = 32'h0000_1000;
  localparam logic [XLEN-1:0] SMASK = 32'h0002_19BB;

  logic clk = 0, rst_n = 0;
  logic trap_valid = 0, trap_is_irq = 0, st_we = 0, priv_we = 0;
  logic [CW-1:0] trap_code = '0;
  logic [XLEN-1:0] trap_pc = '0, trap_tval = '0, st_wdata = '0;
  logic [XLEN-1:0] m_ideleg = '0, m_edeleg = '0, s_ideleg = '0, s_edeleg = '0;
  logic [XLEN-1:0] m_tvec = '0, s_tvec = '0, u_tvec = '0;
  logic [1:0] priv_wdata = '0;
  logic [1:0] priv;
  logic [XLEN-1:0] status, m_cause, m_epc, m_tval, s_cause, s_epc, s_tval;
  logic [XLEN-1:0] u_cause, u_epc, u_tval, redir_pc;
  logic redir_valid;

  always #4 clk = ~clk;

  trap_entry_ctrl #(.XLEN(XLEN), .RESET_PC(RPC)) dut (.*);

  int checks = 0, errors = 0;
  logic [1:0] e_priv;
  logic [XLEN-1:0] e_st, e_pc;
  logic e_rv;
  logic [XLEN-1:0] e_cause [4], e_epc [4], e_tval [4];

  task automatic chk(input bit ok, input string req, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    e_priv = 2'd3; e_st = '0; e_rv = 0; e_pc = RPC;
    for (int i = 0; i < 4; i++) begin e_cause[i] = '0; e_epc[i] = '0; e_tval[i] = '0; end
  endtask

  task automatic model_step();
    logic [XLEN-1:0] md, sd, tv;
    int lv;
    e_rv = trap_valid;
    if (trap_valid) begin
      md = trap_is_irq ? m_ideleg : m_edeleg;
      sd = trap_is_irq ? s_ideleg : s_edeleg;
      lv = 3;
      if (e_priv != 3 && md[trap_code]) lv = 1;
      if (e_priv == 0 && sd[trap_code]) lv = 0;
      e_cause[lv] = (XLEN'(trap_is_irq) << (XLEN-1)) | XLEN'(trap_code);
      e_epc[lv] = trap_pc;
      e_tval[lv] = trap_tval;
      if (lv == 0) begin e_st[4] = e_st[0]; e_st[0] = 0; tv = u_tvec; end
      else if (lv == 1) begin e_st[8] = (e_priv == 1); e_st[5] = e_st[1]; e_st[1] = 0; tv = s_tvec; end
      else begin e_st[12:11] = e_priv; e_st[7] = e_st[3]; e_st[3] = 0; tv = m_tvec; end
      e_pc = tv & ~XLEN'(3);
      if (trap_is_irq && tv[1:0] == 2'd1) e_pc = e_pc + 4 * XLEN'(trap_code);
      e_priv = 2'(lv);
    end else begin
      if (st_we) e_st = st_wdata & SMASK;
      if (priv_we) e_priv = priv_wdata;
    end
  endtask

  task automatic compare_all();
    chk(priv == e_priv, "R1 R2 R12 priv", XLEN'(priv), XLEN'(e_priv));
    chk(status == e_st, "R5 R6 R7 R11 status", status, e_st);
    chk(m_cause == e_cause[3] && s_cause == e_cause[1] && u_cause == e_cause[0],
        "R3 cause", m_cause ^ s_cause ^ u_cause, e_cause[3] ^ e_cause[1] ^ e_cause[0]);
    chk(m_epc == e_epc[3] && s_epc == e_epc[1] && u_epc == e_epc[0] &&
        m_tval == e_tval[3] && s_tval == e_tval[1] && u_tval == e_tval[0],
        "R4 epc/tval", m_epc ^ s_epc ^ u_epc ^ m_tval, e_epc[3] ^ e_epc[1] ^ e_epc[0] ^ e_tval[3]);
    chk(redir_valid == e_rv, "R9 pulse", XLEN'(redir_valid), XLEN'(e_rv));
    chk(redir_pc == e_pc, "R8 target", redir_pc, e_pc);
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk); #1;
    compare_all();
    @(negedge clk);
    trap_valid = 0; st_we = 0; priv_we = 0;
  endtask

  task automatic reset_check();
    rst_n = 0; model_reset();
    @(negedge clk); #1;
    chk(priv == 2'd3 && status == '0 && m_cause == '0 && s_cause == '0 && u_cause == '0,
        "R10 reset state", status | XLEN'(priv), XLEN'(3));
    chk(redir_pc == RPC && !redir_valid, "R10 reset pc", redir_pc, RPC);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic trap(input bit irq, input int code, input logic [XLEN-1:0] pc);
    trap_valid = 1; trap_is_irq = irq; trap_code = CW'(code);
    trap_pc = pc; trap_tval = pc ^ 32'hA5A5_0000;
    cyc();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    reset_check();
    m_tvec = 32'h8000_0001; s_tvec = 32'h4000_0102; u_tvec = 32'h2000_0203;
    // R11: status write masked
    st_we = 1; st_wdata = '1; cyc();
    // R7 R8: machine exception direct, interrupt vectored
    trap(0, 2, 32'h100); trap(1, 7, 32'h104);
    // R1: drop to S, delegate code 9; R5 stacking; mode 2 is direct (R8)
    m_edeleg = 32'h0000_0200; m_ideleg = 32'h0000_0020;
    st_we = 1; st_wdata = '1; cyc();
    priv_we = 1; priv_wdata = 2'd1; cyc();
    trap(0, 9, 32'h200);
    // R1: from S, not delegated goes to M
    priv_we = 1; priv_wdata = 2'd1; cyc();
    trap(0, 4, 32'h204);
    // R2 R6: user-level handling with supervisor delegation
    s_ideleg = 32'h0000_0020; st_we = 1; st_wdata = '1; cyc();
    priv_we = 1; priv_wdata = 2'd0; cyc();
    trap(1, 5, 32'h300);
    // R2: supervisor mask set but from S stays S
    priv_we = 1; priv_wdata = 2'd1; cyc();
    trap(1, 5, 32'h304);
    // R11 R12: trap with simultaneous writes, trap wins
    st_we = 1; st_wdata = 32'h0000_0008; priv_we = 1; priv_wdata = 2'd0;
    trap(1, 31, 32'h400);
    // R12: idle hold
    cyc(); cyc();
    // random mix
    for (int n = 0; n < 4000; n++) begin
      if (n % 50 == 0) begin
        m_ideleg = $urandom; m_edeleg = $urandom; s_ideleg = $urandom; s_edeleg = $urandom;
        m_tvec = $urandom; s_tvec = $urandom; u_tvec = $urandom;
      end
      trap_valid = ($urandom % 3) == 0; trap_is_irq = $urandom; trap_code = CW'($urandom);
      trap_pc = $urandom; trap_tval = $urandom;
      st_we = ($urandom % 4) == 0; st_wdata = $urandom;
      priv_we = ($urandom % 3) == 0;
      case ($urandom % 3) 0: priv_wdata = 2'd0; 1: priv_wdata = 2'd1; default: priv_wdata = 2'd3; endcase
      cyc();
    end
    // R10: reset with non-zero state
    reset_check();
    cyc();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule